// File: doc/BRIEF.md
# Five-Channel Down-Counting PWM Timer

This block holds five timer channels behind a small synchronous register port. Each channel has a down-counter and, on channels 0 to 3, a compare register that decides where the output pin turns on. Software writes a reload value and a compare value into buffer registers. Those values reach the running counter only through a channel's manual-update bit, or when the counter wraps through zero with auto-reload set. While a channel runs with auto-reload set, its pin carries a periodic waveform. The period is set by the reload value and the duty by the compare value.

Every channel counts ticks, not clocks. Two 8-bit prescalers divide the input clock by (prescale + 1). Channels 0 and 1 use the first prescaler, and channels 2 to 4 use the second. Each channel then applies its own power-of-two divider. Channel 4 has no compare register and no pin. It serves as a plain interval counter whose value software can read back.

Top module: `pwmt_top`

## Requirements
- R1: After reset, every register reads zero, every counter holds zero and every pin is low.
- R2: On each tick, a running counter that is not zero decreases by one. A channel's tick period in clocks is (P + 1) times D. P is the prescale field of its group. D is 2, 4, 8 or 16 for a divider field value of 0, 1, 2 or 3 and above. The divider field of channel c is bits [4c+3:4c] of word address 1.
- R3: Channels 0 and 1 take P from bits [7:0] of word address 0. Channels 2, 3 and 4 take P from bits [15:8] of the same word.
- R4: The internal level of channels 0 to 3 goes high on the tick where a decrement leaves the counter equal to the compare value. It stays high until the next reload, update or stop. A compare value at or above the reload value therefore never raises the level.
- R5: While a channel's update bit (control bit 4c+1) is set, the counter and compare registers copy the buffers and the level goes low. No ticks occur while the bit is set. Counting resumes once the bit is cleared.
- R6: When a tick finds a counter at zero and the auto-reload bit (control bit 4c+3, bit 19 for channel 4) is set, the counter reloads from its buffer and the level goes low. The period is N + 1 ticks, and the high time is C + 1 ticks when C < N.
- R7: When a tick finds a counter at zero and auto-reload is clear, the counter stays at zero and the level goes low.
- R8: Setting the invert bit (control bit 4c+2, channels 0 to 3) inverts pin c.
- R9: The start bit (control bit 4c) gates ticking. While the start bit is clear, the counter keeps its value.
- R10: A buffer write while a channel runs leaves the active counter alone until the next reload or update.
- R11: The control word is at address 2. Channel c has a count buffer at 3+3c, a compare buffer at 4+3c and a read-only counter observation at 5+3c. Channel 4 has no compare: address 16 reads zero and ignores writes. Bit 18 of the control word reads zero, and unused bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the register at addr |
| addr | input | 5 | Word address for both read and write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for addr |
| pwmOut | output | 4 | Output pins of channels 0 to 3 |

## Verification
On every cycle, the assertions check how the counter moves: a decrement by one on a tick, no change without a tick or update, a copy of the buffer on update or on reload at zero, a stop at zero, and the level rising on a compare match. The arithmetic of the tick period, the grouping of the prescalers, the invert bit, the register map and the isolation of buffer writes across full periods can only be shown by the bench's scenarios. Those scenarios measure whole waveforms at the pins and read state back through the register port.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

  // Per-channel strobes handed from control to datapath.
  typedef struct packed {
    logic tick;
    logic load;
    logic autoRel;
  } chanStb_t;

  // Terminal count of the per-channel divider for a select field.
  function automatic logic [3:0] divLast(input logic [3:0] sel);
    case (sel)
      4'd0:    return 4'd1;
      4'd1:    return 4'd3;
      4'd2:    return 4'd7;
      default: return 4'd15;
    endcase
  endfunction

endpackage

// File: rtl/pwmt_ctrl.sv
module pwmt_ctrl
  import pwmt_pkg::*;
#(
  parameter int NUM_CH    = 5,
  parameter int NUM_PIN   = 4,
  parameter int GRP_SPLIT = 2,
  parameter int CNT_W     = 16,
  parameter int DW        = 32,
  parameter int AW        = 5
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           wrEn,
  input  logic [AW-1:0]                  addr,
  input  logic [DW-1:0]                  wrData,
  output logic [DW-1:0]                  rdData,
  input  logic [NUM_CH-1:0][CNT_W-1:0]   cntObs,
  output chanStb_t [NUM_CH-1:0]          stb,
  output logic [NUM_CH-1:0][CNT_W-1:0]   cntBufOut,
  output logic [NUM_PIN-1:0][CNT_W-1:0]  cmpBufOut,
  output logic [NUM_PIN-1:0]             invOut
);

  localparam int PRE_W   = 8;
  localparam int FLD     = 4;
  localparam int ADR_PRE = 0;
  localparam int ADR_SEL = 1;
  localparam int ADR_CTL = 2;
  localparam int ADR_CH0 = 3;
  localparam int STRIDE  = 3;
  localparam int B_START = 0;
  localparam int B_UPD   = 1;
  localparam int B_INV   = 2;
  localparam int B_AR    = 3;

  function automatic logic [DW-1:0] mkCtlMask();
    logic [DW-1:0] m;
    m = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      m[FLD*c+B_START] = 1'b1;
      m[FLD*c+B_UPD]   = 1'b1;
      m[FLD*c+B_AR]    = 1'b1;
      if (c < NUM_PIN) m[FLD*c+B_INV] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [DW-1:0] mkSelMask();
    logic [DW-1:0] m;
    m = '0;
    for (int c = 0; c < NUM_CH; c++) m[FLD*c +: FLD] = '1;
    return m;
  endfunction

  function automatic logic [DW-1:0] mkPreMask();
    logic [DW-1:0] m;
    m = '0;
    m[2*PRE_W-1:0] = '1;
    return m;
  endfunction

  localparam logic [DW-1:0] CTL_MASK = mkCtlMask();
  localparam logic [DW-1:0] SEL_MASK = mkSelMask();
  localparam logic [DW-1:0] PRE_MASK = mkPreMask();

  logic [DW-1:0]                 preReg;
  logic [DW-1:0]                 selReg;
  logic [DW-1:0]                 ctlReg;
  logic [NUM_CH-1:0][CNT_W-1:0]  cntBufR;
  logic [NUM_PIN-1:0][CNT_W-1:0] cmpBufR;
  logic [1:0]                    preTick;

  // Register writes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      preReg  <= '0;
      selReg  <= '0;
      ctlReg  <= '0;
      cntBufR <= '0;
      cmpBufR <= '0;
    end else if (wrEn) begin
      if (addr == AW'(ADR_PRE)) preReg <= wrData & PRE_MASK;
      if (addr == AW'(ADR_SEL)) selReg <= wrData & SEL_MASK;
      if (addr == AW'(ADR_CTL)) ctlReg <= wrData & CTL_MASK;
      for (int i = 0; i < NUM_CH; i++) begin
        if (addr == AW'(ADR_CH0 + STRIDE*i)) cntBufR[i] <= wrData[CNT_W-1:0];
      end
      for (int i = 0; i < NUM_PIN; i++) begin
        if (addr == AW'(ADR_CH0 + STRIDE*i + 1)) cmpBufR[i] <= wrData[CNT_W-1:0];
      end
    end
  end

  // Register reads
  always_comb begin
    rdData = '0;
    if (addr == AW'(ADR_PRE)) rdData = preReg;
    if (addr == AW'(ADR_SEL)) rdData = selReg;
    if (addr == AW'(ADR_CTL)) rdData = ctlReg;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == AW'(ADR_CH0 + STRIDE*i))     rdData = DW'(cntBufR[i]);
      if (addr == AW'(ADR_CH0 + STRIDE*i + 2)) rdData = DW'(cntObs[i]);
    end
    for (int i = 0; i < NUM_PIN; i++) begin
      if (addr == AW'(ADR_CH0 + STRIDE*i + 1)) rdData = DW'(cmpBufR[i]);
    end
  end

  // Shared prescalers, one per channel group
  for (genvar g = 0; g < 2; g++) begin : g_pre
    logic [PRE_W-1:0] preCnt;
    logic [PRE_W-1:0] preVal;
    assign preVal     = preReg[PRE_W*g +: PRE_W];
    assign preTick[g] = (preCnt >= preVal);
    always_ff @(posedge clk) begin
      if (!rstN)          preCnt <= '0;
      else if (preTick[g]) preCnt <= '0;
      else                preCnt <= preCnt + PRE_W'(1);
    end
  end

  // Per-channel dividers and strobes
  for (genvar c = 0; c < NUM_CH; c++) begin : g_div
    localparam int GRP = (c < GRP_SPLIT) ? 0 : 1;
    logic [3:0] divCnt;
    logic [3:0] lastVal;
    logic       runBit;
    logic       updBit;
    logic       wrapHit;
    assign runBit  = ctlReg[FLD*c+B_START];
    assign updBit  = ctlReg[FLD*c+B_UPD];
    assign lastVal = divLast(selReg[FLD*c +: FLD]);
    assign wrapHit = preTick[GRP] && (divCnt >= lastVal);
    always_ff @(posedge clk) begin
      if (!rstN)                divCnt <= '0;
      else if (!runBit || updBit) divCnt <= '0;
      else if (preTick[GRP])    divCnt <= wrapHit ? 4'd0 : divCnt + 4'd1;
    end
    assign stb[c].tick    = runBit && !updBit && wrapHit;
    assign stb[c].load    = updBit;
    assign stb[c].autoRel = ctlReg[FLD*c+B_AR];
    assign cntBufOut[c]   = cntBufR[c];
  end

  for (genvar p = 0; p < NUM_PIN; p++) begin : g_pinCfg
    assign cmpBufOut[p] = cmpBufR[p];
    assign invOut[p]    = ctlReg[FLD*p+B_INV];
  end

endmodule

// File: rtl/pwmt_datapath.sv
module pwmt_datapath
  import pwmt_pkg::*;
#(
  parameter int NUM_CH  = 5,
  parameter int NUM_PIN = 4,
  parameter int CNT_W   = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  chanStb_t [NUM_CH-1:0]          stb,
  input  logic [NUM_CH-1:0][CNT_W-1:0]   cntBuf,
  input  logic [NUM_PIN-1:0][CNT_W-1:0]  cmpBuf,
  output logic [NUM_CH-1:0][CNT_W-1:0]   cntAct,
  output logic [NUM_PIN-1:0][CNT_W-1:0]  cmpAct,
  output logic [NUM_PIN-1:0]             lvl
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cntDec;
    logic             atZero;
    assign cntDec    = cnt - CNT_W'(1);
    assign atZero    = (cnt == '0);
    assign cntAct[c] = cnt;

    always_ff @(posedge clk) begin
      if (!rstN)                        cnt <= '0;
      else if (stb[c].load)             cnt <= cntBuf[c];
      else if (stb[c].tick) begin
        if (!atZero)                    cnt <= cntDec;
        else if (stb[c].autoRel)        cnt <= cntBuf[c];
      end
    end

    if (c < NUM_PIN) begin : g_cmp
      logic [CNT_W-1:0] cmpR;
      logic             lv;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          cmpR <= '0;
          lv   <= 1'b0;
        end else if (stb[c].load) begin
          cmpR <= cmpBuf[c];
          lv   <= 1'b0;
        end else if (stb[c].tick) begin
          if (atZero) begin
            lv <= 1'b0;
            if (stb[c].autoRel) cmpR <= cmpBuf[c];
          end else if (cntDec == cmpR) begin
            lv <= 1'b1;
          end
        end
      end
      assign cmpAct[c] = cmpR;
      assign lvl[c]    = lv;
    end
  end

endmodule

// File: rtl/pwmt_top.sv
module pwmt_top
  import pwmt_pkg::*;
#(
  parameter int NUM_CH    = 5,
  parameter int NUM_PIN   = 4,
  parameter int GRP_SPLIT = 2,
  parameter int CNT_W     = 16,
  parameter int DW        = 32,
  parameter int AW        = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wrData,
  output logic [DW-1:0]      rdData,
  output logic [NUM_PIN-1:0] pwmOut
);

  chanStb_t [NUM_CH-1:0]          stb;
  logic [NUM_CH-1:0][CNT_W-1:0]   cntBufW;
  logic [NUM_PIN-1:0][CNT_W-1:0]  cmpBufW;
  logic [NUM_PIN-1:0]             invW;
  logic [NUM_CH-1:0][CNT_W-1:0]   cntAct;
  logic [NUM_PIN-1:0][CNT_W-1:0]  cmpAct;
  logic [NUM_PIN-1:0]             lvl;

  pwmt_ctrl #(
    .NUM_CH(NUM_CH), .NUM_PIN(NUM_PIN), .GRP_SPLIT(GRP_SPLIT),
    .CNT_W(CNT_W), .DW(DW), .AW(AW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .cntObs(cntAct), .stb(stb), .cntBufOut(cntBufW),
    .cmpBufOut(cmpBufW), .invOut(invW)
  );

  pwmt_datapath #(
    .NUM_CH(NUM_CH), .NUM_PIN(NUM_PIN), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cntBuf(cntBufW), .cmpBuf(cmpBufW),
    .cntAct(cntAct), .cmpAct(cmpAct), .lvl(lvl)
  );

  assign pwmOut = lvl ^ invW;

endmodule

// File: rtl/pwmt_chk.sv
module pwmt_chk
  import pwmt_pkg::*;
#(
  parameter int NUM_CH  = 5,
  parameter int NUM_PIN = 4,
  parameter int CNT_W   = 16
) (
  input logic                           clk,
  input logic                           rstN,
  input chanStb_t [NUM_CH-1:0]          stb,
  input logic [NUM_CH-1:0][CNT_W-1:0]   cntBuf,
  input logic [NUM_CH-1:0][CNT_W-1:0]   cntAct,
  input logic [NUM_PIN-1:0][CNT_W-1:0]  cmpAct,
  input logic [NUM_PIN-1:0]             lvl
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    a_r2_count_down: assert property (@(posedge clk) disable iff (!rstN)
      (stb[i].tick && !stb[i].load && cntAct[i] != '0)
      |=> cntAct[i] == $past(cntAct[i]) - CNT_W'(1));

    a_r9_hold_no_tick: assert property (@(posedge clk) disable iff (!rstN)
      (!stb[i].tick && !stb[i].load) |=> $stable(cntAct[i]));

    a_r5_update_copy: assert property (@(posedge clk) disable iff (!rstN)
      stb[i].load |=> cntAct[i] == $past(cntBuf[i]));

    a_r5_update_no_tick: assert property (@(posedge clk) disable iff (!rstN)
      stb[i].load |-> !stb[i].tick);

    a_r6_reload: assert property (@(posedge clk) disable iff (!rstN)
      (stb[i].tick && !stb[i].load && cntAct[i] == '0 && stb[i].autoRel)
      |=> cntAct[i] == $past(cntBuf[i]));

    a_r7_stop_zero: assert property (@(posedge clk) disable iff (!rstN)
      (stb[i].tick && !stb[i].load && cntAct[i] == '0 && !stb[i].autoRel)
      |=> cntAct[i] == '0);

    if (i < NUM_PIN) begin : g_pin
      a_r4_match_high: assert property (@(posedge clk) disable iff (!rstN)
        (stb[i].tick && !stb[i].load && cntAct[i] != '0 &&
         cntAct[i] - CNT_W'(1) == cmpAct[i]) |=> lvl[i]);

      a_r7_zero_low: assert property (@(posedge clk) disable iff (!rstN)
        (stb[i].tick && !stb[i].load && cntAct[i] == '0) |=> !lvl[i]);

      a_r5_update_low: assert property (@(posedge clk) disable iff (!rstN)
        stb[i].load |=> !lvl[i]);
    end
  end

endmodule

bind pwmt_top pwmt_chk #(
  .NUM_CH(NUM_CH), .NUM_PIN(NUM_PIN), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .stb(stb), .cntBuf(cntBufW),
  .cntAct(cntAct), .cmpAct(cmpAct), .lvl(lvl)
);

// File: tb/pwmt_top_bench.sv
module pwmt_top_bench;

  localparam int NPIN = 4;
  localparam int AW   = 5;
  localparam int DW   = 32;
  localparam int ROWS = 8;

  // ch, preA, preB, sel, N, C, inv
  localparam int VT [ROWS][7] = '{
    '{0, 0, 0, 0, 10,  3, 0},
    '{1, 1, 0, 1,  6,  0, 0},
    '{2, 3, 1, 0,  8,  5, 1},
    '{3, 0, 2, 2,  4,  1, 0},
    '{0, 2, 5, 0, 12, 11, 1},
    '{2, 0, 0, 3,  3,  2, 0},
    '{1, 0, 0, 0,  7,  7, 0},
    '{3, 1, 1, 0,  5,  9, 0}
  };

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            wrEn = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [DW-1:0]   wrData = '0;
  logic [DW-1:0]   rdData;
  logic [NPIN-1:0] pwmOut;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  pwmt_top u_pwmt_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .pwmOut(pwmOut)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: got %0d cycles exp below 150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %0d exp %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = AW'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] v);
    @(negedge clk);
    addr = AW'(a);
    #1 v = rdData;
  endtask

  logic [DW-1:0] v, o1, o2, o3;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 18; a++) begin
      rd(a, v);
      chk(v == 0, "R1 reset register", v, 0);
    end
    chk(pwmOut == 0, "R1 reset pins", pwmOut, 0);

    // R11 register map
    wr(16, 1234); rd(16, v); chk(v == 0, "R11 ch4 compare absent", v, 0);
    wr(3, 77);    rd(3, v);  chk(v == 77, "R11 ch0 count buffer", v, 77);
    wr(4, 55);    rd(4, v);  chk(v == 55, "R11 ch0 compare buffer", v, 55);
    wr(5, 99);    rd(5, v);  chk(v == 0, "R11 observe read-only", v, 0);
    wr(2, 32'hFFFF_FFFF); rd(2, v);
    chk(v == 32'h000B_FFFF, "R11 control mask", v, 32'h000B_FFFF);
    wr(2, 0);
    wr(1, 32'hFFFF_FFFF); rd(1, v);
    chk(v == 32'h000F_FFFF, "R11 divider mask", v, 32'h000F_FFFF);
    wr(0, 32'hFFFF_FFFF); rd(0, v);
    chk(v == 32'h0000_FFFF, "R11 prescale mask", v, 32'h0000_FFFF);
    wr(0, 0); wr(1, 0);

    // R2 R3 R4 R6 R8 waveform table
    for (int r = 0; r < ROWS; r++) begin
      int ch, pa, pb, sl, n, c, inv, t, hi, lo, cnt;
      bit act, seen;
      ch = VT[r][0]; pa = VT[r][1]; pb = VT[r][2]; sl = VT[r][3];
      n = VT[r][4]; c = VT[r][5]; inv = VT[r][6];
      t = ((ch < 2) ? pa + 1 : pb + 1) * (2 << sl);
      wr(2, 0);
      wr(0, (pb << 8) | pa);
      wr(1, sl << (4*ch));
      wr(3 + 3*ch, n);
      wr(4 + 3*ch, c);
      wr(2, (2 | 8 | (inv << 2)) << (4*ch));
      @(negedge clk);
      chk(pwmOut[ch] == inv[0], "R8 idle pin polarity", pwmOut[ch], inv);
      wr(2, (1 | 8 | (inv << 2)) << (4*ch));
      if (c >= n) begin
        seen = 0;
        repeat (3*(n+1)*t + 20) begin
          @(negedge clk);
          if ((pwmOut[ch] ^ inv[0]) == 1'b1) seen = 1;
        end
        chk(!seen, "R4 compare at or above count never high", seen, 0);
      end else begin
        cnt = 0;
        act = pwmOut[ch] ^ inv[0];
        while (act && cnt < 5000) begin @(negedge clk); act = pwmOut[ch] ^ inv[0]; cnt++; end
        while (!act && cnt < 5000) begin @(negedge clk); act = pwmOut[ch] ^ inv[0]; cnt++; end
        hi = 0; lo = 0;
        while (act && cnt < 5000) begin hi++; @(negedge clk); act = pwmOut[ch] ^ inv[0]; cnt++; end
        while (!act && cnt < 5000) begin lo++; @(negedge clk); act = pwmOut[ch] ^ inv[0]; cnt++; end
        chk(hi == (c+1)*t, "R4 R6 high time", hi, (c+1)*t);
        chk(lo == (n-c)*t, "R2 R3 R6 low time", lo, (n-c)*t);
      end
    end
    wr(2, 0); wr(0, 0); wr(1, 0);

    // R5 update holds, then counting resumes
    wr(6, 100);
    wr(2, (1 | 2) << 4);
    repeat (20) @(negedge clk);
    rd(8, v); chk(v == 100, "R5 update copies and holds", v, 100);
    wr(2, 1 << 4);
    repeat (21) @(negedge clk);
    rd(8, v); chk(v < 100 && v >= 85, "R5 counting resumes", v, 90);
    // R9 start cleared freezes the counter
    wr(2, 0);
    rd(8, o1);
    repeat (30) @(negedge clk);
    rd(8, o2); chk(o1 == o2, "R9 frozen when stopped", o2, o1);

    // R7 stop at zero, channel 4 and channel 0
    wr(15, 5);
    wr(2, 2 << 16);
    wr(2, 1 << 16);
    repeat (40) @(negedge clk);
    rd(17, v); chk(v == 0, "R7 ch4 stops at zero", v, 0);
    wr(2, (1 | 8) << 16);
    repeat (4) @(negedge clk);
    rd(17, v); chk(v > 0 && v <= 5, "R6 ch4 auto-reload bit", v, 5);
    wr(2, 0);
    wr(3, 4); wr(4, 2);
    wr(2, 2); wr(2, 1);
    repeat (40) @(negedge clk);
    chk(pwmOut[0] == 1'b0, "R7 ch0 pin inactive at stop", pwmOut[0], 0);
    rd(5, v); chk(v == 0, "R7 ch0 counter held at zero", v, 0);

    // R10 buffer write while running
    wr(2, 0);
    wr(3, 30); wr(4, 10);
    wr(2, 2 | 8); wr(2, 1 | 8);
    repeat (10) @(negedge clk);
    rd(5, o1);
    wr(3, 200);
    rd(5, o2); chk(o2 <= 30, "R10 active count untouched", o2, o1);
    repeat (80) @(negedge clk);
    rd(5, o3); chk(o3 > 30 && o3 <= 200, "R10 new value after reload", o3, 200);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule